// File: doc/BRIEF.md
# Workload-Driven Supply and Clock Operating Point Sequencer

This block selects one of five supply-voltage and clock-frequency operating points for a baseband processing engine. The choice depends on the workload it is running. A workload is described by two numbers: the number of active users, and the constraint length of the convolutional decoder in use. Software or a workload monitor presents that pair together with a one-cycle change strobe. The block maps the pair to an operating point through a table that is fixed at elaboration.

The block then sequences the move so that the logic is never clocked faster than its supply allows. When the new point is higher, the voltage code goes up first and the frequency code follows once the regulator has settled. When the new point is lower, the frequency code drops first and the voltage code follows. The settling window is a cycle count taken from an input and forced into the range 100 to 1000. Completion also waits for the regulator to report ready.

A strobe that arrives during a transition is held and handled once the transition finishes. A request for the point already in use leaves both codes untouched.

Top module: `dvfs_opp_ctrl`

## Requirements
- R1: After reset the block sits at the highest point, with voltCode = 56, freqCode = 1200, settled = 1 and busy = 0.
- R2: voltCode is the supply in 25 mV steps and freqCode is the clock in MHz. The table is as follows. (4,7), (4,9) and (8,7) give 35/433. (8,9) and (16,7) give 38/533. (16,9) gives 42/667. (32,7) gives 52/1000. (32,9) gives 56/1200. Each pair is written (users, constraint length).
- R3: Any pair that is not in the table selects the highest point, 56/1200.
- R4: When moving to a higher point with regReady held high, voltCode changes first. freqCode changes exactly L+1 cycles later, where L is the clamped settle count.
- R5: When moving to a lower point, freqCode changes first and voltCode changes one cycle later. settled returns L+1 cycles after the voltCode change.
- R6: L equals settleCycles clamped to the range 100 to 1000.
- R7: While regReady is low, a transition never completes, however long the settling count has expired.
- R8: A request that maps to the point already in use leaves voltCode and freqCode unchanged.
- R9: A strobe that arrives while busy is latched. It is served after the current transition ends, and its point is the one finally reached.
- R10: busy is the inverse of settled. settled is low from the cycle after a strobe until the requested point is reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | One-cycle workload change strobe |
| reqUsers | input | 6 | Active user count |
| reqConstraint | input | 4 | Decoder constraint length |
| settleCycles | input | 11 | Requested regulator settling count (clamped 100..1000) |
| regReady | input | 1 | Regulator reports output in regulation |
| voltCode | output | 6 | Requested supply in 25 mV steps |
| freqCode | output | 11 | Selected clock in MHz |
| busy | output | 1 | Transition in progress or pending |
| settled | output | 1 | Current point valid |

## Verification
The hardest situation to reach is a second strobe that lands inside a settling window. The held request must survive, and it must not produce an extra settled pulse before its own transition. To get there, the stimulus starts a raise, waits twenty cycles into the window, and strobes a lowering pair. The scoreboard then expects exactly one completion, carrying the second pair's codes. Holding regReady low past a full 1000-cycle window is the other deliberate reach. The settle inputs of 5 and 2000 exercise both clamp edges with exact cycle counts.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;
  localparam int USER_W = 6;
  localparam int CLEN_W = 4;
  localparam int VOLT_W = 6;
  localparam int FREQ_W = 11;
  localparam int NUM_PTS = 5;
  localparam int PT_W = $clog2(NUM_PTS);

  typedef logic [PT_W-1:0] pt_t;
  localparam pt_t TOP_PT = pt_t'(NUM_PTS - 1);

  typedef struct packed {
    logic takeReq;
    logic setVolt;
    logic setFreq;
    logic cntClr;
    logic commit;
  } dvfs_ctl_t;

  function automatic pt_t lookupPt(input logic [USER_W-1:0] users,
                                   input logic [CLEN_W-1:0] clen);
    pt_t p;
    p = TOP_PT;
    if (clen == CLEN_W'(7)) begin
      case (users)
        USER_W'(4), USER_W'(8): p = pt_t'(0);
        USER_W'(16):            p = pt_t'(1);
        USER_W'(32):            p = pt_t'(3);
        default:                p = TOP_PT;
      endcase
    end else if (clen == CLEN_W'(9)) begin
      case (users)
        USER_W'(4):  p = pt_t'(0);
        USER_W'(8):  p = pt_t'(1);
        USER_W'(16): p = pt_t'(2);
        USER_W'(32): p = pt_t'(4);
        default:     p = TOP_PT;
      endcase
    end
    return p;
  endfunction

  function automatic logic [VOLT_W-1:0] voltOf(input pt_t p);
    case (p)
      pt_t'(0): return VOLT_W'(35);
      pt_t'(1): return VOLT_W'(38);
      pt_t'(2): return VOLT_W'(42);
      pt_t'(3): return VOLT_W'(52);
      default:  return VOLT_W'(56);
    endcase
  endfunction

  function automatic logic [FREQ_W-1:0] freqOf(input pt_t p);
    case (p)
      pt_t'(0): return FREQ_W'(433);
      pt_t'(1): return FREQ_W'(533);
      pt_t'(2): return FREQ_W'(667);
      pt_t'(3): return FREQ_W'(1000);
      default:  return FREQ_W'(1200);
    endcase
  endfunction
endpackage

// File: rtl/dvfs_datapath.sv
module dvfs_datapath
  import dvfs_pkg::*;
#(
  parameter int MIN_SETTLE = 100,
  parameter int MAX_SETTLE = 1000,
  parameter int SETTLE_W = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reqValid,
  input  logic [USER_W-1:0]   reqUsers,
  input  logic [CLEN_W-1:0]   reqConstraint,
  input  logic [SETTLE_W-1:0] settleCycles,
  input  logic                regReady,
  input  dvfs_ctl_t           ctl,
  output logic                pendValid,
  output logic                tgtHigher,
  output logic                tgtEqual,
  output logic                settleDone,
  output pt_t                 curPt,
  output logic [VOLT_W-1:0]   voltCode,
  output logic [FREQ_W-1:0]   freqCode
);
  localparam logic [SETTLE_W-1:0] LIM_LO = SETTLE_W'(MIN_SETTLE);
  localparam logic [SETTLE_W-1:0] LIM_HI = SETTLE_W'(MAX_SETTLE);

  logic [USER_W-1:0]   pendUsers;
  logic [CLEN_W-1:0]   pendClen;
  pt_t                 tgtPt;
  logic [SETTLE_W-1:0] settleCnt;
  logic [SETTLE_W-1:0] settleLim;

  // pending workload holder; a new strobe wins over consumption
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendValid <= 1'b0;
      pendUsers <= '0;
      pendClen  <= '0;
    end else if (reqValid) begin
      pendValid <= 1'b1;
      pendUsers <= reqUsers;
      pendClen  <= reqConstraint;
    end else if (ctl.takeReq) begin
      pendValid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgtPt    <= TOP_PT;
      curPt    <= TOP_PT;
      voltCode <= voltOf(TOP_PT);
      freqCode <= freqOf(TOP_PT);
    end else begin
      if (ctl.takeReq) tgtPt <= lookupPt(pendUsers, pendClen);
      if (ctl.setVolt) voltCode <= voltOf(tgtPt);
      if (ctl.setFreq) freqCode <= freqOf(tgtPt);
      if (ctl.commit)  curPt <= tgtPt;
    end
  end

  always_comb begin
    if (settleCycles < LIM_LO)      settleLim = LIM_LO;
    else if (settleCycles > LIM_HI) settleLim = LIM_HI;
    else                            settleLim = settleCycles;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 settleCnt <= '0;
    else if (ctl.cntClr)        settleCnt <= '0;
    else if (settleCnt < LIM_HI) settleCnt <= settleCnt + 1'b1;
  end

  assign settleDone = (settleCnt >= settleLim) && regReady;
  assign tgtHigher  = tgtPt > curPt;
  assign tgtEqual   = tgtPt == curPt;

  // R6/R7: a transition completes only after the clamped window with the regulator ready
  a_r6_commit_after_window: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.commit |-> (settleCnt >= LIM_LO) && regReady);

  // R2: once a transition ends the outputs match the committed point
  a_r2_codes_match_point: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.commit |=> (voltCode == voltOf(curPt)) && (freqCode == freqOf(curPt)));
endmodule

// File: rtl/dvfs_ctrl.sv
module dvfs_ctrl
  import dvfs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pendValid,
  input  logic      tgtHigher,
  input  logic      tgtEqual,
  input  logic      settleDone,
  output dvfs_ctl_t ctl,
  output logic      ctrlIdle
);
  typedef enum logic [2:0] {S_IDLE, S_DECIDE, S_RAISE, S_LOWV, S_LOWW} st_t;
  st_t st, nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= S_IDLE;
    else        st <= nxt;
  end

  always_comb begin
    ctl = '0;
    nxt = st;
    case (st)
      S_IDLE: if (pendValid) begin
        ctl.takeReq = 1'b1;
        nxt = S_DECIDE;
      end
      S_DECIDE: begin
        if (tgtEqual) nxt = S_IDLE;
        else if (tgtHigher) begin
          ctl.setVolt = 1'b1;
          ctl.cntClr  = 1'b1;
          nxt = S_RAISE;
        end else begin
          ctl.setFreq = 1'b1;
          nxt = S_LOWV;
        end
      end
      S_RAISE: if (settleDone) begin
        ctl.setFreq = 1'b1;
        ctl.commit  = 1'b1;
        nxt = S_IDLE;
      end
      S_LOWV: begin
        ctl.setVolt = 1'b1;
        ctl.cntClr  = 1'b1;
        nxt = S_LOWW;
      end
      S_LOWW: if (settleDone) begin
        ctl.commit = 1'b1;
        nxt = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  assign ctrlIdle = (st == S_IDLE);

  // R9: a held request is picked up on the next idle cycle
  a_r9_pending_served: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && pendValid) |=> (st == S_DECIDE));

  // R5: a lowering frequency step is always followed by the voltage step
  a_r5_lower_sequence: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DECIDE && !tgtEqual && !tgtHigher) |=> (st == S_LOWV));
endmodule

// File: rtl/dvfs_opp_ctrl.sv
module dvfs_opp_ctrl
  import dvfs_pkg::*;
#(
  parameter int MIN_SETTLE = 100,
  parameter int MAX_SETTLE = 1000,
  parameter int SETTLE_W = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reqValid,
  input  logic [5:0]          reqUsers,
  input  logic [3:0]          reqConstraint,
  input  logic [SETTLE_W-1:0] settleCycles,
  input  logic                regReady,
  output logic [5:0]          voltCode,
  output logic [10:0]         freqCode,
  output logic                busy,
  output logic                settled
);
  dvfs_ctl_t ctl;
  logic pendValid, tgtHigher, tgtEqual, settleDone, ctrlIdle;
  pt_t  curPt;

  dvfs_datapath #(
    .MIN_SETTLE(MIN_SETTLE), .MAX_SETTLE(MAX_SETTLE), .SETTLE_W(SETTLE_W)
  ) uDp (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqUsers(reqUsers),
    .reqConstraint(reqConstraint), .settleCycles(settleCycles),
    .regReady(regReady), .ctl(ctl), .pendValid(pendValid),
    .tgtHigher(tgtHigher), .tgtEqual(tgtEqual), .settleDone(settleDone),
    .curPt(curPt), .voltCode(voltCode), .freqCode(freqCode)
  );

  dvfs_ctrl uCtrl (
    .clk(clk), .rst_n(rst_n), .pendValid(pendValid), .tgtHigher(tgtHigher),
    .tgtEqual(tgtEqual), .settleDone(settleDone), .ctl(ctl), .ctrlIdle(ctrlIdle)
  );

  assign busy    = !ctrlIdle || pendValid;
  assign settled = !busy;

  // R4: a frequency rise never coincides with a voltage step
  a_r4_raise_volt_first: assert property (@(posedge clk) disable iff (!rst_n)
    (freqCode > $past(freqCode)) |-> (voltCode == $past(voltCode)));

  // R5: a voltage drop never coincides with a frequency step
  a_r5_lower_freq_first: assert property (@(posedge clk) disable iff (!rst_n)
    (voltCode < $past(voltCode)) |-> (freqCode == $past(freqCode)));

  // R10: outputs hold while nothing is in flight
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ($stable(voltCode) && $stable(freqCode)));
endmodule

// File: tb/tb_dvfs_opp_ctrl.sv
module tb_dvfs_opp_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reqValid = 1'b0;
  logic [5:0] reqUsers = '0;
  logic [3:0] reqConstraint = '0;
  logic [10:0] settleCycles = 11'd300;
  logic regReady = 1'b1;
  logic [5:0] voltCode;
  logic [10:0] freqCode;
  logic busy, settled;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;
  logic [16:0] expQ[$];
  logic prevSettled = 1'b1;

  always #5 clk = ~clk;

  dvfs_opp_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqUsers(reqUsers),
    .reqConstraint(reqConstraint), .settleCycles(settleCycles),
    .regReady(regReady), .voltCode(voltCode), .freqCode(freqCode),
    .busy(busy), .settled(settled)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clampL(input int s);
    return (s < 100) ? 100 : (s > 1000) ? 1000 : s;
  endfunction

  // driver: one-cycle strobe, optionally push the expected completion
  task automatic sendReq(input int u, input int k, input bit push, input int ev, input int ef);
    @(negedge clk);
    reqUsers = 6'(u);
    reqConstraint = 4'(k);
    reqValid = 1'b1;
    if (push) expQ.push_back({6'(ev), 11'(ef)});
    @(negedge clk);
    reqValid = 1'b0;
    check(settled == 1'b0 && busy == 1'b1, "R10 settled low after strobe", settled, 0);
  endtask

  task automatic waitSettled();
    int n = 0;
    while (!settled && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  // monitor: compare on every rising settled
  always @(negedge clk) begin
    if (rst_n && settled && !prevSettled) begin
      if (expQ.size() == 0) check(1'b0, "R2 unexpected completion", freqCode, 0);
      else begin
        logic [16:0] e;
        e = expQ.pop_front();
        check(voltCode == e[16:11], "R2 voltCode at completion", voltCode, e[16:11]);
        check(freqCode == e[10:0], "R2 freqCode at completion", freqCode, e[10:0]);
      end
    end
    prevSettled <= settled;
  end

  task automatic measureRaise(input int gap);
    logic [5:0] v0 = voltCode;
    logic [10:0] f0 = freqCode;
    int n = 0;
    while (voltCode == v0 && n < 3000) begin @(negedge clk); n++; end
    check(freqCode == f0, "R4 freq unchanged when volt rises", freqCode, f0);
    n = 0;
    while (freqCode == f0 && n < 3000) begin @(negedge clk); n++; end
    check(n == gap, "R4 raise gap volt to freq", n, gap);
  endtask

  task automatic measureLower(input int gap);
    logic [5:0] v0 = voltCode;
    logic [10:0] f0 = freqCode;
    int n = 0;
    while (freqCode == f0 && n < 3000) begin @(negedge clk); n++; end
    check(voltCode == v0, "R5 volt unchanged when freq drops", voltCode, v0);
    @(negedge clk);
    check(voltCode != v0, "R5 volt drops one cycle after freq", voltCode, v0);
    n = 0;
    while (!settled && n < 3000) begin @(negedge clk); n++; end
    check(n == gap, "R5 lower gap volt to settled", n, gap);
  endtask

  task automatic finishRun();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(voltCode == 6'd56, "R1 reset voltCode", voltCode, 56);
    check(freqCode == 11'd1200, "R1 reset freqCode", freqCode, 1200);
    check(settled == 1'b1 && busy == 1'b0, "R1 reset settled/busy", settled, 1);

    // R5 lowering with L=300
    sendReq(4, 7, 1, 35, 433);
    measureLower(clampL(300) + 1);
    @(negedge clk);

    // R4 raising
    sendReq(16, 9, 1, 42, 667);
    measureRaise(clampL(300) + 1);
    waitSettled();
    @(negedge clk);

    // R8 repeated request keeps codes
    sendReq(16, 9, 1, 42, 667);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(voltCode == 6'd42 && freqCode == 11'd667, "R8 codes unchanged on repeat", freqCode, 667);
    end
    waitSettled();
    @(negedge clk);

    // R6 lower clamp
    settleCycles = 11'd5;
    sendReq(32, 7, 1, 52, 1000);
    measureRaise(clampL(5) + 1);
    waitSettled();
    @(negedge clk);

    // R6 upper clamp
    settleCycles = 11'd2000;
    sendReq(8, 9, 1, 38, 533);
    measureLower(clampL(2000) + 1);
    @(negedge clk);

    // R3 unlisted pair
    settleCycles = 11'd120;
    sendReq(5, 7, 1, 56, 1200);
    waitSettled();
    @(negedge clk);
    check(freqCode == 11'd1200 && voltCode == 6'd56, "R3 unlisted selects top", freqCode, 1200);

    // R2 full table walk
    begin
      int tu[8] = '{4, 4, 8, 8, 16, 16, 32, 32};
      int tk[8] = '{7, 9, 7, 9, 7, 9, 7, 9};
      int tv[8] = '{35, 35, 35, 38, 38, 42, 52, 56};
      int tf[8] = '{433, 433, 433, 533, 533, 667, 1000, 1200};
      for (int i = 0; i < 8; i++) begin
        sendReq(tu[i], tk[i], 1, tv[i], tf[i]);
        waitSettled();
        @(negedge clk);
      end
    end

    // R7 regulator not ready blocks completion
    regReady = 1'b0;
    sendReq(4, 9, 1, 35, 433);
    repeat (1200) @(negedge clk);
    check(busy == 1'b1 && settled == 1'b0, "R7 held while regulator not ready", busy, 1);
    regReady = 1'b1;
    waitSettled();
    @(negedge clk);

    // R9 request during busy is latched; single completion with final point
    settleCycles = 11'd150;
    sendReq(32, 9, 0, 0, 0);
    repeat (20) @(negedge clk);
    check(busy == 1'b1, "R9 still busy mid window", busy, 1);
    sendReq(8, 7, 1, 35, 433);
    waitSettled();
    @(negedge clk);
    check(freqCode == 11'd433 && voltCode == 6'd35, "R9 latched request served", freqCode, 433);
    check(expQ.size() == 0, "R9 all expected completions seen", expQ.size(), 0);

    done = 1;
    finishRun();
  end
endmodule